// File: doc/BRIEF.md
# Log/Antilog Galois-Field Byte Arithmetic Unit

This unit computes in the byte field used by AES, GF(2^8) reduced by x^8+x^4+x^3+x+1 (0x11B). Products and inverses are never formed with shift-and-reduce logic. Each operand is first turned into its discrete logarithm with respect to the generator 0x03. The exponents are then added or negated modulo 255, and the result exponent is turned back into an element. Sums of elements are a plain XOR.

Two 256-entry byte tables hold the mappings: one from element to exponent, and one from exponent to element. Together they use 512 bytes, and the same pair serves forward and inverse cipher work. Both tables are computed from the generator while the design elaborates. Each carries a sentinel entry: zero maps to exponent 255, and exponent 255 maps back to zero. Because of this, inverting zero yields zero without any separate zero test.

The caller presents an opcode and two operand bytes with a valid strobe. Two clock edges later it receives the result byte with a one-cycle done pulse. A new operation may start on every cycle.

Top module: `gf_logalu`

## Requirements
- R1: While reset is asserted, and after it is released until the first operation completes, `out_done` is 0 and `out_result` is 0x00.
- R2: For every cycle in which `in_valid` is sampled high at a rising edge, `out_done` is high for exactly one cycle, following the second rising edge after that edge. Operations issued on consecutive cycles complete on consecutive cycles, and `out_done` is low in every other cycle.
- R3: Opcode 0 (add) returns `in_a` XOR `in_b`.
- R4: Opcode 1 (multiply) returns the product of `in_a` and `in_b` in GF(2^8) modulo 0x11B, for every one of the 65536 operand pairs.
- R5: Opcode 1 returns 0x00 whenever either operand is 0x00.
- R6: Opcode 2 (invert) returns the multiplicative inverse of a nonzero `in_a`, so that the product of the operand and the result is 0x01.
- R7: Opcode 2 maps 0x00 to 0x00 and 0x01 to 0x01.
- R8: Under opcode 2, `in_b` has no effect on the result.
- R9: Opcode 3 is reserved and returns 0x00 regardless of the operands.
- R10: `out_result` keeps its last value in every cycle in which `out_done` is low.
- R11: When the exponents of the two multiplicands sum to exactly 255, the product is 0x01. For example, 0x03 times 0xF6 gives 0x01, because 0xF6 is 0x03 raised to the power 254.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Start strobe; operands and opcode are sampled while it is high |
| in_op | input | 2 | Opcode: 0 add, 1 multiply, 2 invert, 3 reserved |
| in_a | input | 8 | First operand; the element inverted under opcode 2 |
| in_b | input | 8 | Second operand; ignored under opcode 2 |
| out_done | output | 1 | One-cycle completion pulse |
| out_result | output | 8 | Result byte, held between completions |

## Verification
The hardest cases are the wrap points of the exponent arithmetic, and they cannot be aimed at directly because the exponents never appear at the ports. These cases are an exponent sum of exactly 255, a sum just past it, and the sentinel exponent entering a sum or a negation. To reach them, the stimulus sweeps every multiply operand pair and every invert operand back to back at full rate, and adds the directed pair whose exponents sum to 255. Randomly gapped traffic with zero-biased operands then exercises the sentinel together with completion timing.

// File: rtl/gf_logalu_pkg.sv
package gf_logalu_pkg;

  localparam int GF_W   = 8;
  localparam int GF_N   = 1 << GF_W;
  localparam int GF_ORD = GF_N - 1;

  typedef logic [GF_W-1:0]           elem_t;
  typedef logic [GF_N-1:0][GF_W-1:0] table_t;

  // low bits of the reduction polynomial 0x11B and the chosen generator
  localparam elem_t GF_RED   = 8'h1B;
  localparam elem_t GF_GEN   = 8'h03;
  localparam elem_t EXP_SENT = elem_t'(GF_ORD);

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_MUL = 2'd1,
    OP_INV = 2'd2,
    OP_RSV = 2'd3
  } op_e;

  function automatic elem_t gf_xtime(elem_t x);
    return {x[GF_W-2:0], 1'b0} ^ (x[GF_W-1] ? GF_RED : elem_t'(0));
  endfunction

  function automatic elem_t gf_times_gen(elem_t x);
    elem_t acc;
    elem_t run;
    acc = '0;
    run = x;
    for (int k = 0; k < GF_W; k++) begin
      if (GF_GEN[k]) acc = acc ^ run;
      run = gf_xtime(run);
    end
    return acc;
  endfunction

  // exponent -> element, entry GF_ORD is the zero sentinel
  function automatic table_t build_antilog();
    table_t t;
    elem_t  p;
    t = '0;
    p = elem_t'(1);
    for (int i = 0; i < GF_ORD; i++) begin
      t[i] = p;
      p    = gf_times_gen(p);
    end
    t[GF_ORD] = '0;
    return t;
  endfunction

  // element -> exponent, entry 0 is the sentinel exponent
  function automatic table_t build_log();
    table_t t;
    elem_t  p;
    t = '0;
    p = elem_t'(1);
    for (int i = 0; i < GF_ORD; i++) begin
      t[p] = elem_t'(i);
      p    = gf_times_gen(p);
    end
    t[0] = EXP_SENT;
    return t;
  endfunction

endpackage

// File: rtl/gf_tab_rom.sv
module gf_tab_rom
  import gf_logalu_pkg::*;
#(
  parameter bit ANTILOG = 1'b0
) (
  input  logic  clk,
  input  logic  rd_en,
  input  elem_t addr,
  output elem_t q
);

  localparam table_t TBL = ANTILOG ? build_antilog() : build_log();

  elem_t q_d;

  always_comb begin
    q_d = rd_en ? TBL[addr] : q;
  end

  // data-only storage, no reset needed
  always_ff @(posedge clk) begin
    q <= q_d;
  end

endmodule

// File: rtl/gf_exp_unit.sv
module gf_exp_unit
  import gf_logalu_pkg::*;
(
  input  op_e   op,
  input  elem_t lg_a,
  input  elem_t lg_b,
  output elem_t exp_o
);

  logic [GF_W:0] sum_raw;
  logic [GF_W:0] sum_red;
  elem_t         mul_exp;
  elem_t         neg_exp;
  elem_t         inv_exp;
  logic          any_zero;

  always_comb begin
    sum_raw = {1'b0, lg_a} + {1'b0, lg_b};
    sum_red = (sum_raw >= (GF_W+1)'(GF_ORD)) ? (sum_raw - (GF_W+1)'(GF_ORD)) : sum_raw;
    any_zero = (lg_a == EXP_SENT) || (lg_b == EXP_SENT);
    mul_exp  = any_zero ? EXP_SENT : sum_red[GF_W-1:0];
  end

  // negation with sentinel trick: out-of-range results reuse the input exponent
  always_comb begin
    neg_exp = EXP_SENT - lg_a;
    if ((neg_exp != '0) && (neg_exp != EXP_SENT)) inv_exp = neg_exp;
    else                                            inv_exp = lg_a;
  end

  always_comb begin
    exp_o = (op == OP_INV) ? inv_exp : mul_exp;
  end

endmodule

// File: rtl/gf_logalu.sv
module gf_logalu
  import gf_logalu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] in_op,
  input  logic [7:0] in_a,
  input  logic [7:0] in_b,
  output logic       out_done,
  output logic [7:0] out_result
);

  localparam int NPORT = 2;

  elem_t opnd [NPORT];
  elem_t lg   [NPORT];

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  // one log-table read port per operand
  for (genvar k = 0; k < NPORT; k++) begin : g_logport
    gf_tab_rom #(.ANTILOG(1'b0)) u_log (
      .clk   (clk),
      .rd_en (in_valid),
      .addr  (opnd[k]),
      .q     (lg[k])
    );
  end

  // stage 1 state
  logic  s1_vld_q, s1_vld_d;
  op_e   s1_op_q,  s1_op_d;
  elem_t s1_xor_q, s1_xor_d;

  // stage 2 state
  logic  s2_vld_q, s2_vld_d;
  op_e   s2_op_q,  s2_op_d;
  elem_t s2_xor_q, s2_xor_d;

  elem_t res_exp;
  elem_t alog_q;

  always_comb begin
    s1_vld_d = in_valid;
    s1_op_d  = in_valid ? op_e'(in_op) : s1_op_q;
    s1_xor_d = in_valid ? (in_a ^ in_b) : s1_xor_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_op_q  <= OP_ADD;
      s1_xor_q <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s1_op_q  <= s1_op_d;
      s1_xor_q <= s1_xor_d;
    end
  end

  gf_exp_unit u_exp (
    .op    (s1_op_q),
    .lg_a  (lg[0]),
    .lg_b  (lg[1]),
    .exp_o (res_exp)
  );

  gf_tab_rom #(.ANTILOG(1'b1)) u_alog (
    .clk   (clk),
    .rd_en (s1_vld_q),
    .addr  (res_exp),
    .q     (alog_q)
  );

  always_comb begin
    s2_vld_d = s1_vld_q;
    s2_op_d  = s1_vld_q ? s1_op_q  : s2_op_q;
    s2_xor_d = s1_vld_q ? s1_xor_q : s2_xor_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld_q <= 1'b0;
      s2_op_q  <= OP_ADD;
      s2_xor_q <= '0;
    end else begin
      s2_vld_q <= s2_vld_d;
      s2_op_q  <= s2_op_d;
      s2_xor_q <= s2_xor_d;
    end
  end

  always_comb begin
    unique case (s2_op_q)
      OP_ADD:         out_result = s2_xor_q;
      OP_MUL, OP_INV: out_result = alog_q;
      default:        out_result = '0;
    endcase
  end

  assign out_done = s2_vld_q;

endmodule

// File: rtl/gf_logalu_chk.sv
module gf_logalu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] in_op,
  input logic [7:0] in_a,
  input logic [7:0] in_b,
  input logic       out_done,
  input logic [7:0] out_result
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  logic hist2;
  assign hist2 = (age_q == 2'd2);

  p_done_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hist2 |-> (out_done == $past(in_valid, 2)));

  p_add_xor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hist2 && $past(in_valid, 2) && $past(in_op, 2) == 2'd0)
      |-> (out_result == ($past(in_a, 2) ^ $past(in_b, 2))));

  p_mul_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hist2 && $past(in_valid, 2) && $past(in_op, 2) == 2'd1 && $past(in_a, 2) == 8'h01)
      |-> (out_result == $past(in_b, 2)));

  p_mul_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hist2 && $past(in_valid, 2) && $past(in_op, 2) == 2'd1 &&
     ($past(in_a, 2) == 8'h00 || $past(in_b, 2) == 8'h00))
      |-> (out_result == 8'h00));

  p_inv_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hist2 && $past(in_valid, 2) && $past(in_op, 2) == 2'd2 && $past(in_a, 2) <= 8'h01)
      |-> (out_result == $past(in_a, 2)));

  p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hist2 && $past(in_valid, 2) && $past(in_op, 2) == 2'd3) |-> (out_result == 8'h00));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && !out_done) |-> $stable(out_result));

endmodule

bind gf_logalu gf_logalu_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_a       (in_a),
  .in_b       (in_b),
  .out_done   (out_done),
  .out_result (out_result)
);

// File: tb/gf_logalu_bench.sv
`timescale 1ns/1ps
module gf_logalu_bench;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [1:0] in_op;
  logic [7:0] in_a;
  logic [7:0] in_b;
  logic       out_done;
  logic [7:0] out_result;

  int errors = 0;
  int checks = 0;
  bit started = 1'b0;
  bit finished = 1'b0;
  string cur_tag = "";

  gf_logalu u_gf_logalu (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_done   (out_done),
    .out_result (out_result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference arithmetic: shift and XOR modulo 0x11B
  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] run;
    acc = 8'h00;
    run = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ run;
      run = {run[6:0], 1'b0} ^ (run[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] ref_inv(logic [7:0] a);
    if (a == 8'h00) return 8'h00;
    for (int x = 1; x < 256; x++) begin
      if (ref_mul(a, 8'(x)) == 8'h01) return 8'(x);
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] ref_op(logic [1:0] op, logic [7:0] a, logic [7:0] b);
    case (op)
      2'd0:    return a ^ b;
      2'd1:    return ref_mul(a, b);
      2'd2:    return ref_inv(a);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string auto_tag(logic [1:0] op, logic [7:0] a, logic [7:0] b);
    case (op)
      2'd0:    return "R3";
      2'd1:    return (a == 8'h00 || b == 8'h00) ? "R5" : "R4";
      2'd2:    return (a <= 8'h01) ? "R7" : "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected-value pipeline, two edges deep
  logic       p1_v, p2_v;
  logic [7:0] p1_e, p2_e;
  string      p1_t, p2_t;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v <= 1'b0;
      p2_v <= 1'b0;
    end else begin
      p1_v <= in_valid;
      p1_e <= ref_op(in_op, in_a, in_b);
      p1_t <= (cur_tag != "") ? cur_tag : auto_tag(in_op, in_a, in_b);
      p2_v <= p1_v;
      p2_e <= p1_e;
      p2_t <= p1_t;
    end
  end

  logic [7:0] prev_res = 8'h00;

  always @(negedge clk) begin
    if (rst_n && started) begin
      if (p2_v) begin
        chk(out_done == 1'b1, "R2", {7'd0, out_done}, 8'h01);
        chk(out_result == p2_e, p2_t, out_result, p2_e);
      end else begin
        chk(out_done == 1'b0, "R2", {7'd0, out_done}, 8'h00);
        chk(out_result == prev_res, "R10", out_result, prev_res);
      end
      prev_res = out_result;
    end
  end

  task automatic issue(logic [1:0] op, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_a     = a;
    in_b     = b;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_op = 2'd0;
    in_a = 8'h00;
    in_b = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk(out_done == 1'b0, "R1", {7'd0, out_done}, 8'h00);
    chk(out_result == 8'h00, "R1", out_result, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_done == 1'b0, "R1", {7'd0, out_done}, 8'h00);
    chk(out_result == 8'h00, "R1", out_result, 8'h00);
    started = 1'b1;

    // R11: exponent sum exactly 255, plus neighbours
    cur_tag = "R11";
    issue(2'd1, 8'h03, 8'hF6);
    issue(2'd1, 8'hF6, 8'h03);
    issue(2'd1, 8'hF6, 8'hF6);
    idle(3);

    // R3 directed adds
    cur_tag = "R3";
    issue(2'd0, 8'hFF, 8'h0F);
    issue(2'd0, 8'h00, 8'h00);
    issue(2'd0, 8'hA5, 8'hA5);
    idle(3);

    // R9 reserved opcode
    cur_tag = "R9";
    issue(2'd3, 8'hFF, 8'hFF);
    issue(2'd3, 8'h12, 8'h34);
    idle(3);

    // R8: invert with b changing each time, a fixed
    cur_tag = "R8";
    for (int i = 0; i < 16; i++) issue(2'd2, 8'h53, 8'($urandom));
    issue(2'd2, 8'h00, 8'hFF);
    issue(2'd2, 8'h01, 8'h00);
    idle(3);

    // R4/R5 exhaustive multiply, back to back
    cur_tag = "";
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        issue(2'd1, 8'(a), 8'(b));
    idle(3);

    // R6/R7 every element inverted
    for (int a = 0; a < 256; a++) issue(2'd2, 8'(a), 8'(255 - a));
    idle(3);

    // mixed traffic with gaps (R2, R10), zero-biased operands
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ra;
      logic [7:0] rb;
      ra = ($urandom % 8 == 0) ? 8'h00 : 8'($urandom);
      rb = ($urandom % 8 == 0) ? 8'h00 : 8'($urandom);
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_a = 8'($urandom);
        in_b = 8'($urandom);
        in_op = 2'($urandom);
      end else begin
        issue(2'($urandom), ra, rb);
      end
    end
    idle(4);

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%02h expected=%02h", 8'h00, 8'h01);
    summary();
    $finish;
  end

endmodule